// File: doc/BRIEF.md
# Vector Element Reverse Unit

This block performs the element-order reversal operations of a SIMD datapath on a 128-bit vector. It has three variants, which reverse the elements inside every 64-bit, every 32-bit or every 16-bit slice of the vector. The element width is 8, 16, 32 or 64 bits and comes from a two-bit size field. A small decoder takes a 32-bit instruction word in the two-register miscellaneous layout and extracts the full-width flag, the unsigned-variant bit, the size field, the opcode and both register numbers. The decoder output selects the operation and reports encodings that have no meaning.

A strobe on `in_valid` captures the instruction and the source vector. One cycle later the unit presents the result with a single-cycle `out_valid` pulse, an illegal flag, the destination register number and a write enable. The write enable is held low for illegal encodings, so the destination register is not touched. The source register number is decoded combinationally so that the register file can read the operand in the same cycle.

Top module: `vrev_unit`

## Requirements
- R1: While reset is held and after it is released with no strobe, `out_valid` and `out_wr_en` are 0.
- R2: Let sel = 2*opcode[0] + U. Opcode 0 with U=0 reverses within 64-bit slices, opcode 0 with U=1 within 32-bit slices, and opcode 1 with U=0 within 16-bit slices. With size 0 (bytes), the byte order of each such slice is fully reversed.
- R3: With element width 8<<size bits and k = 3 - (sel + size), source element i goes to destination element i XOR ((1<<k)-1).
- R4: The encoding is illegal when sel + size is 3 or more, or when opcode bits 4:1 are not all zero. An illegal encoding sets `out_illegal`, holds `out_wr_en` low and gives a zero `out_vec`.
- R5: When Q is 0, only the low 64 bits take part in the operation and bits 127:64 of the result are zero. When Q is 1, all 128 bits take part.
- R6: Results appear in the cycle after an `in_valid` strobe, and `out_valid` is high for exactly that one cycle.
- R7: Field positions in the instruction word: Q at bit 30, U at bit 29, size at bits 23:22, opcode at bits 16:12, Rn at bits 9:5 and Rd at bits 4:0. `src_reg` shows Rn combinationally. `out_rd` shows the captured Rd together with the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe that captures `insn` and `src_vec` |
| insn | input | 32 | Instruction word in the two-register miscellaneous layout |
| src_vec | input | 128 | Source vector operand |
| src_reg | output | 5 | Decoded source register number (combinational) |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_illegal | output | 1 | Captured encoding was illegal |
| out_wr_en | output | 1 | Destination write enable, low for illegal encodings |
| out_rd | output | 5 | Captured destination register number |
| out_vec | output | 128 | Result vector |

## Verification
The bench runs every combination of opcode bit 0, U, size and Q on three source patterns. An incrementing byte ramp shows which byte went where. A single high-half marker pattern exposes leakage across the 64-bit boundary when Q is 0. A dense irregular constant catches lanes that are swapped or stuck. Each result is compared with an element-level reference model. The size values that give illegal sums and the opcodes above 1 confirm that the flag is set, the write enable stays low and the vector is zero.

// File: rtl/vrev_pkg.sv
// Package: shared constants, the decoded-field record and the lane-key function
// for the vector element reverse unit.
// Assumes byte-granular lanes and a narrow (half) width of 64 bits.
package vrev_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned NARROW_W = 64;
    localparam int unsigned KEY_W    = 3;

    typedef struct packed {
        logic       full;
        logic       uflag;
        logic [1:0] esize;
        logic [4:0] opc;
        logic [4:0] src_reg;
        logic [4:0] dst_reg;
    } rev_fields_t;

    // Byte XOR key: group bytes minus element bytes. For a legal encoding this
    // equals ((1<<k)-1) << size, with k = 3 - (sel + size).
    function automatic logic [KEY_W-1:0] lane_key(input logic [1:0] sel,
                                                  input logic [1:0] esize);
        logic [3:0] grp_bytes;
        logic [3:0] elem_bytes;
        logic [3:0] diff;
        grp_bytes  = 4'd8 >> sel;
        elem_bytes = 4'd1 << esize;
        diff       = grp_bytes - elem_bytes;
        return diff[KEY_W-1:0];
    endfunction
endpackage

// File: rtl/vrev_decode.sv
// Module: vrev_decode
// Extracts the fields of a two-register miscellaneous instruction word, forms the
// combined selector, flags encodings that have no meaning and derives the byte
// XOR key that drives the permutation. Purely combinational.
// Assumes only opcodes 0 and 1 belong to this unit; any other opcode is illegal here.
module vrev_decode
    import vrev_pkg::*;
(
    input  logic [31:0]      insn,
    output rev_fields_t      fields,
    output logic             illegal,
    output logic [KEY_W-1:0] key
);
    logic [1:0] sel;
    logic [2:0] sel_plus_size;
    logic       unused_bits;

    // Bits that belong to other parts of the format and are not used here.
    assign unused_bits = ^{insn[31], insn[28:24], insn[21:17], insn[11:10]};

    // Field extraction, legality check and key derivation.
    always_comb begin
        fields.full    = insn[30];
        fields.uflag   = insn[29];
        fields.esize   = insn[23:22];
        fields.opc     = insn[16:12];
        fields.src_reg = insn[9:5];
        fields.dst_reg = insn[4:0];
        sel            = {insn[12], insn[29]};
        sel_plus_size  = {1'b0, sel} + {1'b0, insn[23:22]};
        illegal        = (sel_plus_size >= 3'd3) || (insn[16:13] != 4'd0);
        key            = lane_key(sel, insn[23:22]);
    end
endmodule

// File: rtl/vrev_permute.sv
// Module: vrev_permute
// Byte-lane crossbar. Destination byte d takes source byte d XOR key. A key below
// 8 keeps every lane inside its own 64-bit half. Lanes above the narrow width are
// zeroed when the full-width flag is clear.
// Assumes VEC_W is a multiple of 64 and key values below 8.
module vrev_permute
    import vrev_pkg::*;
#(
    parameter int unsigned VEC_W = 128
)(
    input  logic [VEC_W-1:0] src,
    input  logic [KEY_W-1:0] key,
    input  logic             full,
    output logic [VEC_W-1:0] dst
);
    localparam int unsigned LANES        = VEC_W / BYTE_W;
    localparam int unsigned LW           = $clog2(LANES);
    localparam int unsigned NARROW_LANES = NARROW_W / BYTE_W;

    for (genvar d = 0; d < LANES; d++) begin : g_lane
        logic [LW-1:0] sidx;

        // Source lane index for this destination lane.
        assign sidx = LW'(d) ^ LW'(key);

        if (d < NARROW_LANES) begin : g_low
            // Low half: always active.
            assign dst[d*BYTE_W +: BYTE_W] = src[{sidx, 3'b000} +: BYTE_W];
        end else begin : g_high
            // High half: active only at full width.
            assign dst[d*BYTE_W +: BYTE_W] = full ? src[{sidx, 3'b000} +: BYTE_W]
                                                  : {BYTE_W{1'b0}};
        end
    end
endmodule

// File: rtl/vrev_unit.sv
// Module: vrev_unit (top)
// Vector element reverse unit: decodes the instruction word, permutes the source
// vector and registers the result, illegal flag, write enable and destination
// number one cycle after an in_valid strobe.
// Assumes a single clock and a synchronous active-low reset.
module vrev_unit
    import vrev_pkg::*;
#(
    parameter int unsigned VEC_W = 128
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      insn,
    input  logic [VEC_W-1:0] src_vec,
    output logic [4:0]       src_reg,
    output logic             out_valid,
    output logic             out_illegal,
    output logic             out_wr_en,
    output logic [4:0]       out_rd,
    output logic [VEC_W-1:0] out_vec
);
    rev_fields_t      fields;
    logic             illegal;
    logic [KEY_W-1:0] key;
    logic [VEC_W-1:0] permuted;

    vrev_decode u_decode (
        .insn    (insn),
        .fields  (fields),
        .illegal (illegal),
        .key     (key)
    );

    vrev_permute #(.VEC_W(VEC_W)) u_permute (
        .src  (src_vec),
        .key  (key),
        .full (fields.full),
        .dst  (permuted)
    );

    // Source register number goes straight out for the operand read.
    assign src_reg = fields.src_reg;

    // Valid pulse and write enable: one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_wr_en <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_wr_en <= in_valid && !illegal;
        end
    end

    // Result capture on the strobe; illegal encodings give a zero vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_illegal <= 1'b0;
            out_rd      <= 5'd0;
            out_vec     <= '0;
        end else if (in_valid) begin
            out_illegal <= illegal;
            out_rd      <= fields.dst_reg;
            out_vec     <= illegal ? '0 : permuted;
        end
    end
endmodule

// File: rtl/vrev_unit_chk.sv
// Module: vrev_unit_chk
// Protocol and datapath properties for vrev_unit, attached by the bind at the
// end of this file.
// Assumes the same VEC_W as the bound instance.
module vrev_unit_chk #(
    parameter int unsigned VEC_W = 128
)(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      insn,
    input logic [VEC_W-1:0] src_vec,
    input logic             out_valid,
    input logic             out_illegal,
    input logic             out_wr_en,
    input logic [4:0]       out_rd,
    input logic [VEC_W-1:0] out_vec
);
    // Strobe gives a result pulse in the next cycle.
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // No strobe gives no pulse.
    assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // Size 3 is illegal for every selector: flag set, no write.
    assert_size3_illegal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[23:22] == 2'b11) |=> (out_illegal && !out_wr_en));

    // Write enable only with a legal result pulse.
    assert_wr_needs_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> (out_valid && !out_illegal));

    // Narrow operations leave the high half zero.
    assert_high_zero_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !insn[30]) |=> (out_vec[VEC_W-1:64] == '0));

    // Byte reverse in 64-bit slices: lowest result byte is the top source byte of the slice.
    assert_rev64_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[16:12] == 5'd0 && !insn[29] && insn[23:22] == 2'b00)
        |=> (out_vec[7:0] == $past(src_vec[63:56])));

    // Destination number captured from bits 4:0.
    assert_rd_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_rd == $past(insn[4:0])));
endmodule

bind vrev_unit vrev_unit_chk #(.VEC_W(VEC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .insn        (insn),
    .src_vec     (src_vec),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_wr_en   (out_wr_en),
    .out_rd      (out_rd),
    .out_vec     (out_vec)
);

// File: tb/vrev_unit_tb_top.sv
// Bench: exhaustive sweep of opcode bit 0, U, size and Q over three source
// patterns, plus out-of-range opcodes. Expected results come from an
// element-level reference model.
module vrev_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [31:0]  insn;
    logic [127:0] src_vec;
    logic [4:0]   src_reg;
    logic         out_valid;
    logic         out_illegal;
    logic         out_wr_en;
    logic [4:0]   out_rd;
    logic [127:0] out_vec;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vrev_unit #(.VEC_W(128)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .insn        (insn),
        .src_vec     (src_vec),
        .src_reg     (src_reg),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_wr_en   (out_wr_en),
        .out_rd      (out_rd),
        .out_vec     (out_vec)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference: element i goes to slot i ^ (elements_per_group - 1).
    function automatic logic [127:0] ref_model(input int sel, input int sz, input bit q,
                                               input logic [127:0] src);
        logic [127:0] res = '0;
        int width = q ? 128 : 64;
        int esz   = 8 << sz;
        int grp   = 64 >> sel;
        int mask  = grp / esz - 1;
        for (int i = 0; i < width / esz; i++)
            for (int b = 0; b < esz; b++)
                res[(i ^ mask) * esz + b] = src[i * esz + b];
        return res;
    endfunction

    function automatic logic [31:0] mk_insn(input int opc, input bit u, input int sz,
                                            input bit q, input int rn, input int rd);
        logic [31:0] w = '0;
        w[30]    = q;
        w[29]    = u;
        w[23:22] = sz[1:0];
        w[16:12] = opc[4:0];
        w[9:5]   = rn[4:0];
        w[4:0]   = rd[4:0];
        return w;
    endfunction

    task automatic run_op(input int opc, input bit u, input int sz, input bit q,
                          input logic [127:0] src, input int tag);
        int  sel = 2 * (opc & 1) + int'(u);
        bit  bad = (sel + sz >= 3) || (opc > 1);
        int  rn  = (tag * 7 + 3) & 31;
        int  rd  = (tag * 5 + 1) & 31;
        logic [127:0] exp;
        @(negedge clk);
        insn     = mk_insn(opc, u, sz, q, rn, rd);
        src_vec  = src;
        in_valid = 1'b1;
        #1;
        check("R7 src_reg", 128'(src_reg), 128'(rn));
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 out_valid pulse", 128'(out_valid), 128'd1);
        check("R7 out_rd", 128'(out_rd), 128'(rd));
        if (bad) begin
            check("R4 illegal flag", 128'(out_illegal), 128'd1);
            check("R4 wr_en low", 128'(out_wr_en), 128'd0);
            check("R4 zero vector", out_vec, 128'd0);
        end else begin
            exp = ref_model(sel, sz, q, src);
            check("R4 legal flag", 128'(out_illegal), 128'd0);
            check("R4 wr_en high", 128'(out_wr_en), 128'd1);
            if (!q)        check("R5 narrow result", out_vec, exp);
            else if (sz == 0) check("R2 byte reverse", out_vec, exp);
            else           check("R3 element reverse", out_vec, exp);
        end
        @(negedge clk);
        check("R6 single pulse", 128'(out_valid), 128'd0);
    endtask

    initial begin
        logic [127:0] pats [3];
        int tag = 0;
        pats[0] = 128'h0f0e0d0c0b0a09080706050403020100;
        pats[1] = 128'hA5000000000000000000000000000000;
        pats[2] = 128'h3c91e7d4b2086f5a1dc3479e80f62b5d;
        rst_n = 1'b0; in_valid = 1'b0; insn = '0; src_vec = '0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 128'(out_valid), 128'd0);
        check("R1 reset wr_en", 128'(out_wr_en), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", 128'(out_valid), 128'd0);
        check("R1 idle wr_en", 128'(out_wr_en), 128'd0);
        for (int p = 0; p < 3; p++)
            for (int opc = 0; opc < 2; opc++)
                for (int u = 0; u < 2; u++)
                    for (int sz = 0; sz < 4; sz++)
                        for (int q = 0; q < 2; q++) begin
                            run_op(opc, u[0], sz, q[0], pats[p], tag);
                            tag++;
                        end
        // Opcodes outside this unit are illegal (R4).
        run_op(2, 1'b0, 0, 1'b1, pats[2], 90);
        run_op(9, 1'b0, 0, 1'b0, pats[0], 91);
        run_op(16, 1'b1, 1, 1'b1, pats[2], 92);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule